// File: doc/BRIEF.md
# Non-Stoppable Watchdog Down-Counter

This block is a register-mapped watchdog timer for a small system-on-chip. A 32-bit counter moves down by one on every cycle in which the `tick` strobe is high. No register bit can stop or pause it. Software keeps the system alive by writing a fresh value into the counter register. This write is the "kick", and any value is accepted, including all ones.

When the count reaches zero, a sticky expiry flag is set and drives the level interrupt output. Software clears the flag by writing one to it. A control bit decides whether reaching zero also sends a one-cycle request to the system reset controller.

A build-time parameter picks one of two behaviours after the interrupt is acknowledged:
- The counter restarts from all ones and counts towards another expiry.
- The counter stays parked at zero and raises the flag again on the next tick.

Top module: `watchdog_timer`

## Requirements
- R1: After reset the counter holds 0xFFFFFFFF, the expiry flag and `irq` are low, `rst_req` is low and the reset-enable control bit reads 0.
- R2: Each cycle with `tick` high and no counter write lowers a nonzero count by one. Cycles without `tick` leave it unchanged. Writing any control value does not stop the counting.
- R3: When a tick takes the count from 1 to 0, the expiry flag is set on that edge and `irq` stays high until acknowledged. The count never wraps below zero on its own. Status register bit 0 reads the flag.
- R4: Writing a word with bit 0 set to the status register clears the flag. Writing a word with bit 0 clear has no effect on it.
- R5: With `HOLD_AT_ZERO` = 0, acknowledging while the count is zero reloads it to 0xFFFFFFFF, and a later expiry sets the flag again.
- R6: With `HOLD_AT_ZERO` = 1, the count stays at zero after an acknowledge. The next tick sets the flag again without a reset request.
- R7: A write to the counter register loads the written word on the next edge (the kick). Reading that register returns the live count.
- R8: Control register bit 0 enables the reset request. When it is set, `rst_req` is high for exactly the one cycle after the edge on which the count goes from 1 to 0. When it is clear, `rst_req` stays low.
- R9: When a counter write coincides with the tick that would expire the count, the write wins and the flag is not set.
- R10: Register map on `bus_addr`: 0 is the counter, 1 is control (bit 0 only, other bits read 0), 2 is status (bit 0 only). Address 3 reads zero and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable strobe from the timebase |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, equal to the expiry flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The properties assume that a write lasts one cycle and that `bus_addr` and `bus_wdata` are valid whenever `bus_wr` is high. They also assume `tick` is a plain synchronous level with no relation to the bus. Some properties assume that an acknowledge without a tick cannot coincide with an expiry; the properties that assume this exclude the tick case themselves. The stimulus changes every input at the falling edge and holds it for whole cycles. It raises `tick` only for counted stretches, so each expected count is an exact subtraction. Two instances, one per post-acknowledge variant, share the same inputs so that both behaviours are checked against one stimulus.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_CTRL   = 2'd1,
        REG_STATUS = 2'd2,
        REG_NONE   = 2'd3
    } wdt_reg_e;

    typedef struct packed {
        logic flag;
        logic rst_pulse;
    } wdt_flag_t;

endpackage

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int CNT_W        = 32,
    parameter bit HOLD_AT_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ack_en,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o,
    output logic             rezero_o
);
    localparam logic [CNT_W-1:0] CNT_ALL1 = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_zero;
    logic             reload_ack;

    assign at_zero    = (cnt_q == '0);
    assign reload_ack = (HOLD_AT_ZERO == 1'b0) && ack_en && at_zero;

    always_comb begin
        cnt_d = cnt_q;
        if (load_en) begin
            cnt_d = load_val;
        end else if (reload_ack) begin
            cnt_d = CNT_ALL1;
        end else if (tick && !at_zero) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ALL1;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o  = cnt_q;
    assign expire_o = tick && !load_en && (cnt_q == CNT_ONE);
    assign rezero_o = (HOLD_AT_ZERO == 1'b1) && tick && !load_en && at_zero;

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic rezero,
    input  logic ack_en,
    input  logic rst_en,
    output logic flag_o,
    output logic rst_pulse_o
);
    wdt_flag_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = expire && rst_en;
        if (expire || rezero) begin
            st_d.flag = 1'b1;
        end else if (ack_en) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o      = st_q.flag;
    assign rst_pulse_o = st_q.rst_pulse;

endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter bit HOLD_AT_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq,
    output logic             rst_req
);
    localparam int PAD_W = CNT_W - 1;

    wdt_reg_e         sel;
    logic             wr_cnt, wr_ctrl, ack_en;
    logic             ctrl_d, ctrl_q;
    logic [CNT_W-1:0] cnt_val;
    logic             expire, rezero;

    assign sel     = wdt_reg_e'(bus_addr);
    assign wr_cnt  = bus_wr && (sel == REG_COUNT);
    assign wr_ctrl = bus_wr && (sel == REG_CTRL);
    assign ack_en  = bus_wr && (sel == REG_STATUS) && bus_wdata[0];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    wdt_downcount #(
        .CNT_W        (CNT_W),
        .HOLD_AT_ZERO (HOLD_AT_ZERO)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_en  (wr_cnt),
        .load_val (bus_wdata),
        .ack_en   (ack_en),
        .count_o  (cnt_val),
        .expire_o (expire),
        .rezero_o (rezero)
    );

    wdt_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .rezero      (rezero),
        .ack_en      (ack_en),
        .rst_en      (ctrl_q),
        .flag_o      (irq),
        .rst_pulse_o (rst_req)
    );

    always_comb begin
        case (sel)
            REG_COUNT:  bus_rdata = cnt_val;
            REG_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
            REG_STATUS: bus_rdata = {{PAD_W{1'b0}}, irq};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             rst_req,
    input logic             rst_en
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic k_wr, k_ack, k_ack0;
    assign k_wr   = bus_wr && (bus_addr == REG_COUNT);
    assign k_ack  = bus_wr && (bus_addr == REG_STATUS) && bus_wdata[0];
    assign k_ack0 = bus_wr && (bus_addr == REG_STATUS) && !bus_wdata[0];

    assert_tick_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !k_wr && count > ONE) |=> count == $past(count) - ONE);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !k_wr && count != '0) |=> $stable(count));

    assert_expiry_sets_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !k_wr && count == ONE) |=> irq);

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !k_wr && !k_ack) |=> count == '0);

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (k_ack && !tick) |=> !irq);

    assert_zero_write_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (k_ack0 && irq) |=> irq);

    assert_kick_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        k_wr |=> count == $past(bus_wdata));

    assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(rst_en) && $past(count) == ONE && $past(tick)));

    assert_kick_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (k_wr && !irq) |=> !irq);

endmodule

bind watchdog_timer wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (cnt_val),
    .irq       (irq),
    .rst_req   (rst_req),
    .rst_en    (ctrl_q)
);

// File: tb/watchdog_timer_test.sv
module watchdog_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b, rstq_a, rstq_b;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    watchdog_timer #(.CNT_W(32), .HOLD_AT_ZERO(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .irq(irq_a), .rst_req(rstq_a));

    watchdog_timer #(.CNT_W(32), .HOLD_AT_ZERO(1'b1)) uut_b (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .irq(irq_b), .rst_req(rstq_b));

    // load value, tick count, expected count
    localparam logic [95:0] VEC [0:4] = '{
        {32'd100,        32'd5,  32'd95},
        {32'd3,          32'd2,  32'd1},
        {32'hFFFF_FFFF,  32'd7,  32'hFFFF_FFF8},
        {32'd16,         32'd16, 32'd0},
        {32'd2,          32'd4,  32'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] da, output logic [31:0] db);
        bus_addr = a;
        #1;
        da = rdata_a;
        db = rdata_b;
    endtask

    logic [31:0] va, vb;

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, va, vb);
        check("R1 count A", va, 32'hFFFF_FFFF);
        check("R1 count B", vb, 32'hFFFF_FFFF);
        check("R1 irq", {31'd0, irq_a}, 32'd0);
        check("R1 rst_req", {31'd0, rstq_a}, 32'd0);
        rd(2'd1, va, vb);
        check("R1 ctrl", va, 32'd0);

        // table walk: R2, R3, R5 (ack at zero reloads)
        for (int i = 0; i < 5; i++) begin
            wr(2'd0, VEC[i][95:64]);
            ticks(int'(VEC[i][63:32]));
            @(negedge clk);
            rd(2'd0, va, vb);
            check("R2 table count", va, VEC[i][31:0]);
            check("R3 table irq", {31'd0, irq_a}, {31'd0, VEC[i][31:0] == 32'd0});
            check("R8 no rst when disabled", {31'd0, rstq_a}, 32'd0);
            wr(2'd2, 32'd1);
            check("R4 table ack", {31'd0, irq_a}, 32'd0);
        end

        // R10 map and R2 no stopping via control
        rd(2'd3, va, vb);
        check("R10 addr3 reads zero", va, 32'd0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, va, vb);
        check("R10 ctrl only bit0", va, 32'd1);
        wr(2'd1, 32'd0);
        wr(2'd0, 32'd10);
        wr(2'd3, 32'd55);
        rd(2'd0, va, vb);
        check("R10 addr3 write ignored", va, 32'd10);
        wr(2'd1, 32'hFFFF_FFFE);
        ticks(3);
        rd(2'd0, va, vb);
        check("R2 control cannot stop", va, 32'd7);
        repeat (4) @(negedge clk);
        rd(2'd0, va, vb);
        check("R2 no tick holds", va, 32'd7);

        // R3/R4/R5/R6 acknowledge behaviour
        wr(2'd0, 32'd1);
        ticks(1);
        check("R3 irq on expiry", {31'd0, irq_a}, 32'd1);
        check("R8 rst_req off", {31'd0, rstq_a}, 32'd0);
        rd(2'd2, va, vb);
        check("R3 status reads flag", va, 32'd1);
        wr(2'd2, 32'd0);
        check("R4 zero write no effect", {31'd0, irq_a}, 32'd1);
        wr(2'd2, 32'd1);
        check("R4 ack clears A", {31'd0, irq_a}, 32'd0);
        check("R4 ack clears B", {31'd0, irq_b}, 32'd0);
        rd(2'd0, va, vb);
        check("R5 reload after ack", va, 32'hFFFF_FFFF);
        check("R6 hold at zero", vb, 32'd0);
        ticks(1);
        rd(2'd0, va, vb);
        check("R5 counts on", va, 32'hFFFF_FFFE);
        check("R6 stays zero", vb, 32'd0);
        check("R6 re-interrupt", {31'd0, irq_b}, 32'd1);
        check("R6 no rst_req", {31'd0, rstq_b}, 32'd0);
        check("R5 no early irq", {31'd0, irq_a}, 32'd0);
        wr(2'd0, 32'd1);
        ticks(1);
        check("R5 later expiry", {31'd0, irq_a}, 32'd1);
        wr(2'd2, 32'd1);

        // R8 reset request pulse
        wr(2'd1, 32'd1);
        wr(2'd0, 32'd2);
        ticks(2);
        check("R8 rst_req pulse", {31'd0, rstq_a}, 32'd1);
        check("R8 irq with rst", {31'd0, irq_a}, 32'd1);
        @(negedge clk);
        check("R8 single cycle", {31'd0, rstq_a}, 32'd0);
        wr(2'd2, 32'd1);
        wr(2'd1, 32'd0);

        // R9 kick beats expiry
        wr(2'd0, 32'd1);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'd50;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(2'd0, va, vb);
        check("R9 write wins count", va, 32'd50);
        check("R9 no irq", {31'd0, irq_a}, 32'd0);

        // R7 kick with all ones
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, va, vb);
        check("R7 kick readback", va, 32'hFFFF_FFFF);
        ticks(2);
        rd(2'd0, va, vb);
        check("R7 live count", va, 32'hFFFF_FFFD);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule